// File: doc/BRIEF.md
# Packet Buffer Pointer and Data Port

This block gives a host processor access to packet memory through a narrow window: a 16-bit pointer register and a data register. The pointer holds an 11-bit byte offset inside one packet together with control bits that choose the receive or transmit area, the direction of the data accesses that follow, and whether the offset steps forward after each access. The packet number is taken, at the moment the pointer is committed, either from the head of the receive-done queue or from the transmit packet number input.

In read mode the block fetches dwords from memory ahead of the host into a small prefetch queue and holds the host off with a ready signal until data is present. In write mode host accesses are queued with byte enables and drained to memory one per cycle, and a status bit in the pointer readback shows whether queued writes are still pending. The readback always shows the host-side offset, so an interrupt handler can save and restore it while prefetch runs ahead.

Top module: `pkt_ptr_port`

## Requirements
- R1: After reset the pointer readback is 0. A low-byte pointer write only stages the low address byte; a high-byte write commits the pointer. High byte layout: bit 7 receive area, bit 6 auto-step, bit 5 read mode, bit 4 early transmit check, bit 3 ignored on write, bits 2:0 address bits 10:8. Readback places these at bits 15..11 (bit 11 is the pending-write flag) and the address at bits 10:0.
- R2: With auto-step set, each accepted data access advances the readback address by 1 for size code 0 (byte), 2 for size code 1 (16-bit) and 4 for size code 2 (32-bit), wrapping at 11 bits.
- R3: With auto-step clear, a committed address has bits 1:0 forced to zero and `misalign_err` is 1 if the staged low byte had either bit set (0 otherwise); accesses then leave the address unchanged and all go to that same dword.
- R4: The packet number used for memory accesses is latched on commit: the receive-done head when the receive bit is set, otherwise the transmit packet number; later changes on those inputs do not affect it.
- R5: After a read-mode commit, `host_rdy` is low in the following cycle and stays low until the prefetch queue holds data; a read returns bytes of the dword at the pointer, lane selected by address bits 1:0, zero-extended to the access size.
- R6: Prefetch fetches dwords ahead of the host without changing the readback address, which only tracks accepted host accesses.
- R7: A new pointer commit discards all prefetched and in-flight data; the next read returns data from the new address.
- R8: In write mode, accepted writes are queued with data shifted to the byte lane of the address and byte enables for the size, drained one per cycle; readback bit 11 is 1 while any queued write has not reached memory.
- R9: A data read in write mode or a data write in read mode is ignored: no memory access and no address step.
- R10: `early_tx_en` and readback bit 12 follow the committed early transmit bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ptr_wr_lo | input | 1 | Stage low pointer byte |
| ptr_wr_hi | input | 1 | Write high pointer byte and commit |
| ptr_wdata | input | 8 | Pointer byte data |
| ptr_rdata | output | 16 | Pointer readback |
| dat_rd | input | 1 | Data read request, held until accepted |
| dat_wr | input | 1 | Data write request, held until accepted |
| dat_size | input | 2 | Access size code: 0 byte, 1 16-bit, 2 32-bit |
| dat_wdata | input | 32 | Write data, right-aligned |
| dat_rdata | output | 32 | Read data, right-aligned |
| host_rdy | output | 1 | Access is accepted in this cycle |
| tx_pkt_num | input | PNW | Transmit packet number |
| rx_done_pkt | input | PNW | Head of receive-done queue |
| early_tx_en | output | 1 | Early transmit underrun check enable |
| misalign_err | output | 1 | Last commit had a misaligned fixed address |
| mem_rd_req | output | 1 | Memory dword read, data expected next cycle |
| mem_rd_pkt | output | PNW | Packet number of read |
| mem_rd_addr | output | 9 | Dword address of read |
| mem_rd_data | input | 32 | Read data, one cycle after request |
| mem_wr_req | output | 1 | Memory write |
| mem_wr_pkt | output | PNW | Packet number of write |
| mem_wr_addr | output | 9 | Dword address of write |
| mem_wr_data | output | 32 | Write data in byte lanes |
| mem_wr_be | output | 4 | Byte enables |

## Verification
On every cycle the checker covers the ready drop after a read-mode commit, the prefetch queue bound, the readback address holding when no access or commit happens, fixed addresses under auto-step off, forced alignment on commit, reads issued only in read mode and writes draining only while the pending flag is shown. The values returned on reads, the byte-lane merging into memory, the latching of the packet number, the flush on reload and the ignored wrong-direction accesses need the bench's scenarios, which compare against its own memory model.

// File: rtl/pkt_ptr_pkg.sv
package pkt_ptr_pkg;
  localparam int PTR_AW  = 11;
  localparam int DWA_W   = PTR_AW - 2;
  localparam int DATA_W  = 32;
  localparam int BE_W    = DATA_W / 8;

  typedef struct packed {
    logic rx_area;
    logic auto_inc;
    logic rd_mode;
    logic early_tx;
  } ptr_ctl_t;

  // bytes covered by an access size code
  function automatic logic [2:0] step_bytes(input logic [1:0] sz);
    case (sz)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  // byte enables for a size placed at a lane offset
  function automatic logic [BE_W-1:0] lane_mask(input logic [1:0] sz, input logic [1:0] off);
    logic [BE_W-1:0] base;
    case (sz)
      2'd0:    base = 4'b0001;
      2'd1:    base = 4'b0011;
      default: base = 4'b1111;
    endcase
    return base << off;
  endfunction

  // pick bytes of a dword and zero-extend to the size
  function automatic logic [DATA_W-1:0] lane_extract(input logic [DATA_W-1:0] dw,
                                                     input logic [1:0] off,
                                                     input logic [1:0] sz);
    logic [DATA_W-1:0] sh;
    sh = dw >> {off, 3'b000};
    case (sz)
      2'd0:    return {24'h0, sh[7:0]};
      2'd1:    return {16'h0, sh[15:0]};
      default: return sh;
    endcase
  endfunction

  // true when an access leaves the current prefetched dword
  function automatic logic leaves_dword(input logic [1:0] off, input logic [1:0] sz,
                                        input logic ainc);
    return !ainc || ((3'(off) + step_bytes(sz)) >= 3'd4);
  endfunction
endpackage

// File: rtl/pkt_ptr_reg.sv
module pkt_ptr_reg
  import pkt_ptr_pkg::*;
#(
  parameter int PNW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [7:0]        wdata,
  input  logic              acc_fire,
  input  logic [1:0]        acc_size,
  input  logic [PNW-1:0]    rx_head,
  input  logic [PNW-1:0]    tx_pnum,
  output ptr_ctl_t          ctl,
  output logic [PTR_AW-1:0] addr,
  output logic [DWA_W-1:0]  load_dw,
  output logic [PNW-1:0]    pkt,
  output logic              commit,
  output logic              misalign
);
  localparam int HI_AW = PTR_AW - 8;

  logic [7:0]        lo_q;
  logic [PTR_AW-1:0] raw_addr;
  logic [PTR_AW-1:0] new_addr;
  ptr_ctl_t          new_ctl;
  logic              unused_ro_bit;

  assign unused_ro_bit = wdata[3];
  assign commit   = wr_hi;
  assign new_ctl  = '{rx_area: wdata[7], auto_inc: wdata[6], rd_mode: wdata[5], early_tx: wdata[4]};
  assign raw_addr = {wdata[HI_AW-1:0], lo_q};
  assign new_addr = new_ctl.auto_inc ? raw_addr : {raw_addr[PTR_AW-1:2], 2'b00};
  assign load_dw  = new_addr[PTR_AW-1:2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q     <= '0;
      ctl      <= '0;
      addr     <= '0;
      pkt      <= '0;
      misalign <= 1'b0;
    end else begin
      if (wr_lo && !wr_hi) lo_q <= wdata;
      if (commit) begin
        ctl      <= new_ctl;
        addr     <= new_addr;
        pkt      <= new_ctl.rx_area ? rx_head : tx_pnum;
        misalign <= !new_ctl.auto_inc && (raw_addr[1:0] != 2'b00);
      end else if (acc_fire && ctl.auto_inc) begin
        addr <= addr + PTR_AW'(step_bytes(acc_size));
      end
    end
  end
endmodule

// File: rtl/pkt_rd_prefetch.sv
module pkt_rd_prefetch
  import pkt_ptr_pkg::*;
#(
  parameter int DEPTH = 2,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic [DWA_W-1:0]  load_dw,
  input  logic              enable,
  input  logic              auto_inc,
  input  logic              pop,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] head,
  output logic              nonempty,
  output logic [CW-1:0]     count,
  output logic              mem_req,
  output logic [DWA_W-1:0]  mem_addr
);
  logic [DATA_W-1:0] buf_q [DEPTH];
  logic [IW-1:0]     rd_idx, wr_idx;
  logic [CW-1:0]     count_q;
  logic              inflight_q;
  logic [DWA_W-1:0]  faddr_q;
  logic [CW:0]       occ;
  logic              push;
  logic              pop_ok;

  function automatic logic [IW-1:0] next_idx(input logic [IW-1:0] i);
    return (i == IW'(DEPTH - 1)) ? '0 : i + 1'b1;
  endfunction

  assign occ      = (CW+1)'(count_q) + (CW+1)'(inflight_q);
  assign mem_req  = enable && !flush && (occ < (CW+1)'(DEPTH));
  assign mem_addr = faddr_q;
  assign push     = inflight_q && !flush;
  assign pop_ok   = pop && (count_q != '0) && !flush;
  assign nonempty = (count_q != '0);
  assign count    = count_q;
  assign head     = buf_q[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_idx     <= '0;
      wr_idx     <= '0;
      count_q    <= '0;
      inflight_q <= 1'b0;
      faddr_q    <= '0;
    end else if (flush) begin
      rd_idx     <= '0;
      wr_idx     <= '0;
      count_q    <= '0;
      inflight_q <= 1'b0;
      faddr_q    <= load_dw;
    end else begin
      inflight_q <= mem_req;
      if (mem_req && auto_inc) faddr_q <= faddr_q + 1'b1;
      if (push)   wr_idx <= next_idx(wr_idx);
      if (pop_ok) rd_idx <= next_idx(rd_idx);
      count_q <= count_q + CW'(push) - CW'(pop_ok);
    end
  end

  always_ff @(posedge clk) begin
    if (push) buf_q[wr_idx] <= mem_rdata;
  end
endmodule

// File: rtl/pkt_wr_drain.sv
module pkt_wr_drain
  import pkt_ptr_pkg::*;
#(
  parameter int PNW   = 6,
  parameter int DEPTH = 4,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [PNW-1:0]    in_pkt,
  input  logic [DWA_W-1:0]  in_addr,
  input  logic [DATA_W-1:0] in_data,
  input  logic [BE_W-1:0]   in_be,
  output logic              full,
  output logic              nonempty,
  output logic              mem_req,
  output logic [PNW-1:0]    mem_pkt,
  output logic [DWA_W-1:0]  mem_addr,
  output logic [DATA_W-1:0] mem_data,
  output logic [BE_W-1:0]   mem_be
);
  logic [PNW-1:0]    pkt_q  [DEPTH];
  logic [DWA_W-1:0]  addr_q [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];
  logic [BE_W-1:0]   be_q   [DEPTH];
  logic [IW-1:0]     rd_idx, wr_idx;
  logic [CW-1:0]     count_q;
  logic              push_ok;

  function automatic logic [IW-1:0] next_idx(input logic [IW-1:0] i);
    return (i == IW'(DEPTH - 1)) ? '0 : i + 1'b1;
  endfunction

  assign full     = (count_q == CW'(DEPTH));
  assign nonempty = (count_q != '0);
  assign push_ok  = push && !full;
  assign mem_req  = nonempty;
  assign mem_pkt  = pkt_q[rd_idx];
  assign mem_addr = addr_q[rd_idx];
  assign mem_data = data_q[rd_idx];
  assign mem_be   = be_q[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_idx  <= '0;
      wr_idx  <= '0;
      count_q <= '0;
    end else begin
      if (push_ok)  wr_idx <= next_idx(wr_idx);
      if (nonempty) rd_idx <= next_idx(rd_idx);
      count_q <= count_q + CW'(push_ok) - CW'(nonempty);
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) begin
      pkt_q[wr_idx]  <= in_pkt;
      addr_q[wr_idx] <= in_addr;
      data_q[wr_idx] <= in_data;
      be_q[wr_idx]   <= in_be;
    end
  end
endmodule

// File: rtl/pkt_ptr_port.sv
module pkt_ptr_port
  import pkt_ptr_pkg::*;
#(
  parameter int PNW      = 6,
  parameter int RD_DEPTH = 2,
  parameter int WR_DEPTH = 4,
  localparam int RCW     = $clog2(RD_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ptr_wr_lo,
  input  logic              ptr_wr_hi,
  input  logic [7:0]        ptr_wdata,
  output logic [15:0]       ptr_rdata,
  input  logic              dat_rd,
  input  logic              dat_wr,
  input  logic [1:0]        dat_size,
  input  logic [DATA_W-1:0] dat_wdata,
  output logic [DATA_W-1:0] dat_rdata,
  output logic              host_rdy,
  input  logic [PNW-1:0]    tx_pkt_num,
  input  logic [PNW-1:0]    rx_done_pkt,
  output logic              early_tx_en,
  output logic              misalign_err,
  output logic              mem_rd_req,
  output logic [PNW-1:0]    mem_rd_pkt,
  output logic [DWA_W-1:0]  mem_rd_addr,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic              mem_wr_req,
  output logic [PNW-1:0]    mem_wr_pkt,
  output logic [DWA_W-1:0]  mem_wr_addr,
  output logic [DATA_W-1:0] mem_wr_data,
  output logic [BE_W-1:0]   mem_wr_be
);
  ptr_ctl_t          ctl;
  logic [PTR_AW-1:0] cur_addr;
  logic [DWA_W-1:0]  load_dw;
  logic [PNW-1:0]    cur_pkt;
  logic              ptr_commit;
  logic              acc_fire, rd_fire, wr_fire, pf_pop;
  logic [DATA_W-1:0] pf_head;
  logic              pf_nonempty;
  logic [RCW-1:0]    rd_count;
  logic              wq_full, wq_nonempty;

  assign rd_fire  = dat_rd && ctl.rd_mode && pf_nonempty && !ptr_commit;
  assign wr_fire  = dat_wr && !ctl.rd_mode && !wq_full && !ptr_commit;
  assign acc_fire = rd_fire || wr_fire;
  assign pf_pop   = rd_fire && leaves_dword(cur_addr[1:0], dat_size, ctl.auto_inc);

  pkt_ptr_reg #(.PNW(PNW)) u_reg (
    .clk(clk), .rst_n(rst_n), .wr_lo(ptr_wr_lo), .wr_hi(ptr_wr_hi), .wdata(ptr_wdata),
    .acc_fire(acc_fire), .acc_size(dat_size), .rx_head(rx_done_pkt), .tx_pnum(tx_pkt_num),
    .ctl(ctl), .addr(cur_addr), .load_dw(load_dw), .pkt(cur_pkt), .commit(ptr_commit),
    .misalign(misalign_err)
  );

  pkt_rd_prefetch #(.DEPTH(RD_DEPTH)) u_pf (
    .clk(clk), .rst_n(rst_n), .flush(ptr_commit), .load_dw(load_dw), .enable(ctl.rd_mode),
    .auto_inc(ctl.auto_inc), .pop(pf_pop), .mem_rdata(mem_rd_data), .head(pf_head),
    .nonempty(pf_nonempty), .count(rd_count), .mem_req(mem_rd_req), .mem_addr(mem_rd_addr)
  );

  pkt_wr_drain #(.PNW(PNW), .DEPTH(WR_DEPTH)) u_wq (
    .clk(clk), .rst_n(rst_n), .push(wr_fire), .in_pkt(cur_pkt),
    .in_addr(cur_addr[PTR_AW-1:2]), .in_data(dat_wdata << {cur_addr[1:0], 3'b000}),
    .in_be(lane_mask(dat_size, cur_addr[1:0])), .full(wq_full), .nonempty(wq_nonempty),
    .mem_req(mem_wr_req), .mem_pkt(mem_wr_pkt), .mem_addr(mem_wr_addr),
    .mem_data(mem_wr_data), .mem_be(mem_wr_be)
  );

  assign mem_rd_pkt  = cur_pkt;
  assign dat_rdata   = lane_extract(pf_head, cur_addr[1:0], dat_size);
  assign host_rdy    = ctl.rd_mode ? pf_nonempty : !wq_full;
  assign early_tx_en = ctl.early_tx;
  assign ptr_rdata   = {ctl.rx_area, ctl.auto_inc, ctl.rd_mode, ctl.early_tx, wq_nonempty, cur_addr};
endmodule

// File: rtl/pkt_ptr_port_chk.sv
module pkt_ptr_port_chk #(
  parameter int RD_DEPTH = 2,
  localparam int RCW     = $clog2(RD_DEPTH + 1)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           ptr_commit,
  input logic [7:0]     ptr_wdata,
  input logic           host_rdy,
  input logic           acc_fire,
  input logic [15:0]    ptr_rdata,
  input logic [RCW-1:0] rd_count,
  input logic           mem_rd_req,
  input logic           mem_wr_req
);
  assert_rdy_low_after_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_commit && ptr_wdata[5] |=> !host_rdy);

  assert_prefetch_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_count <= RCW'(RD_DEPTH));

  assert_ptr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ptr_commit && !acc_fire |=> $stable(ptr_rdata[10:0]));

  assert_fixed_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire && !ptr_rdata[14] |=> $stable(ptr_rdata[10:0]));

  assert_load_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_commit && !ptr_wdata[6] |=> ptr_rdata[1:0] == 2'b00);

  assert_read_only_in_rd_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |-> ptr_rdata[13]);

  assert_drain_flagged_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_req |-> ptr_rdata[11]);
endmodule

bind pkt_ptr_port pkt_ptr_port_chk #(.RD_DEPTH(RD_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .ptr_commit(ptr_commit), .ptr_wdata(ptr_wdata),
  .host_rdy(host_rdy), .acc_fire(acc_fire), .ptr_rdata(ptr_rdata), .rd_count(rd_count),
  .mem_rd_req(mem_rd_req), .mem_wr_req(mem_wr_req)
);

// File: tb/test_pkt_ptr_port.sv
`timescale 1ns/1ps
module test_pkt_ptr_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ptr_wr_lo = 0, ptr_wr_hi = 0;
  logic [7:0]  ptr_wdata = '0;
  logic [15:0] ptr_rdata;
  logic        dat_rd = 0, dat_wr = 0;
  logic [1:0]  dat_size = '0;
  logic [31:0] dat_wdata = '0, dat_rdata;
  logic        host_rdy;
  logic [5:0]  tx_pkt_num = '0, rx_done_pkt = '0;
  logic        early_tx_en, misalign_err;
  logic        mem_rd_req, mem_wr_req;
  logic [5:0]  mem_rd_pkt, mem_wr_pkt;
  logic [8:0]  mem_rd_addr, mem_wr_addr;
  logic [31:0] mem_rd_data = '0, mem_wr_data;
  logic [3:0]  mem_wr_be;

  int checks = 0, errors = 0, cyc = 0, rd_reqs = 0, wr_reqs = 0;
  logic [31:0] mem [4][512];

  always #2.5 clk = ~clk;

  pkt_ptr_port i_pkt_ptr_port (
    .clk(clk), .rst_n(rst_n), .ptr_wr_lo(ptr_wr_lo), .ptr_wr_hi(ptr_wr_hi),
    .ptr_wdata(ptr_wdata), .ptr_rdata(ptr_rdata), .dat_rd(dat_rd), .dat_wr(dat_wr),
    .dat_size(dat_size), .dat_wdata(dat_wdata), .dat_rdata(dat_rdata), .host_rdy(host_rdy),
    .tx_pkt_num(tx_pkt_num), .rx_done_pkt(rx_done_pkt), .early_tx_en(early_tx_en),
    .misalign_err(misalign_err), .mem_rd_req(mem_rd_req), .mem_rd_pkt(mem_rd_pkt),
    .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data), .mem_wr_req(mem_wr_req),
    .mem_wr_pkt(mem_wr_pkt), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .mem_wr_be(mem_wr_be)
  );

  function automatic logic [31:0] pat(input int p, input int dw);
    return (32'(p) * 32'h0101_0000) ^ (32'(dw) * 32'h0000_1357) ^ 32'hA5C3_0F1E;
  endfunction

  // memory model: read data one cycle after request, byte-enabled writes
  always @(posedge clk) begin
    if (mem_rd_req) begin
      mem_rd_data <= mem[mem_rd_pkt[1:0]][mem_rd_addr];
      rd_reqs <= rd_reqs + 1;
    end
    if (mem_wr_req) begin
      for (int b = 0; b < 4; b++)
        if (mem_wr_be[b]) mem[mem_wr_pkt[1:0]][mem_wr_addr][8*b +: 8] <= mem_wr_data[8*b +: 8];
      wr_reqs <= wr_reqs + 1;
    end
  end

  // expected read: little-endian bytes from the model, zero-extended
  function automatic logic [31:0] exp_read(input int p, input int a, input int sz);
    logic [31:0] r = '0;
    int n = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    for (int i = 0; i < n; i++) begin
      int ba = a + i;
      r[8*i +: 8] = mem[p][ba >> 2][8*(ba & 3) +: 8];
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load_ptr(input logic [3:0] ctl, input logic [10:0] a);
    @(negedge clk); ptr_wr_lo = 1; ptr_wdata = a[7:0];
    @(negedge clk); ptr_wr_lo = 0; ptr_wr_hi = 1; ptr_wdata = {ctl, 1'b0, a[10:8]};
    @(negedge clk); ptr_wr_hi = 0;
  endtask

  task automatic host_read(input logic [1:0] sz, output logic [31:0] d);
    @(negedge clk); dat_size = sz; dat_rd = 1; #1;
    while (!host_rdy) begin @(negedge clk); #1; end
    d = dat_rdata;
    @(posedge clk); #1; dat_rd = 0;
  endtask

  task automatic host_write(input logic [1:0] sz, input logic [31:0] d);
    @(negedge clk); dat_size = sz; dat_wdata = d; dat_wr = 1; #1;
    while (!host_rdy) begin @(negedge clk); #1; end
    @(posedge clk); #1; dat_wr = 0;
  endtask

  // control nibble {rx, auto-step, read, early tx}
  localparam logic [3:0] C_RD_AI = 4'b0110, C_WR_AI = 4'b0100, C_RD_FX = 4'b0010, C_WR_FX = 4'b0000;

  task automatic t_reset;
    check(ptr_rdata == 16'h0000, "R1 reset readback", ptr_rdata, 0);
    check(misalign_err == 0 && early_tx_en == 0, "R1 reset flags", {misalign_err, early_tx_en}, 0);
  endtask

  task automatic t_load;
    @(negedge clk); ptr_wr_lo = 1; ptr_wdata = 8'hA4;
    @(negedge clk); ptr_wr_lo = 0;
    check(ptr_rdata == 16'h0000, "R1 low byte only staged", ptr_rdata, 0);
    @(negedge clk); ptr_wr_hi = 1; ptr_wdata = {C_WR_AI, 1'b1, 3'h2};
    @(negedge clk); ptr_wr_hi = 0;
    check(ptr_rdata == 16'h42A4, "R1 commit on high byte", ptr_rdata, 16'h42A4);
  endtask

  task automatic t_prefetch_step;
    logic [31:0] d;
    tx_pkt_num = 6'd2;
    load_ptr(C_RD_AI, 11'h100);
    check(host_rdy == 0, "R5 ready low after read load", host_rdy, 0);
    host_read(2'd0, d); check(d == exp_read(2, 'h100, 0), "R5 byte read", d, exp_read(2, 'h100, 0));
    check(ptr_rdata[10:0] == 11'h101, "R2 byte step", ptr_rdata[10:0], 11'h101);
    host_read(2'd0, d); check(d == exp_read(2, 'h101, 0), "R5 byte lane 1", d, exp_read(2, 'h101, 0));
    host_read(2'd1, d); check(d == exp_read(2, 'h102, 1), "R5 word lane 2", d, exp_read(2, 'h102, 1));
    check(ptr_rdata[10:0] == 11'h104, "R2 word step", ptr_rdata[10:0], 11'h104);
    host_read(2'd2, d); check(d == exp_read(2, 'h104, 2), "R5 dword read", d, exp_read(2, 'h104, 2));
    host_read(2'd2, d); check(d == exp_read(2, 'h108, 2), "R5 refill read", d, exp_read(2, 'h108, 2));
    check(ptr_rdata[10:0] == 11'h10C, "R2 dword step", ptr_rdata[10:0], 11'h10C);
  endtask

  task automatic t_ahead;
    int base;
    load_ptr(C_RD_AI, 11'h200);
    base = rd_reqs;
    repeat (6) @(negedge clk);
    check(rd_reqs - base >= 2, "R6 prefetch ran ahead", 32'(rd_reqs - base), 2);
    check(ptr_rdata[10:0] == 11'h200, "R6 readback is host address", ptr_rdata[10:0], 11'h200);
  endtask

  task automatic t_pkt_select;
    logic [31:0] d;
    rx_done_pkt = 6'd1; tx_pkt_num = 6'd2;
    load_ptr(4'b1110, 11'h040);
    rx_done_pkt = 6'd3;
    host_read(2'd2, d);
    check(d == exp_read(1, 'h040, 2), "R4 receive packet latched", d, exp_read(1, 'h040, 2));
    check(ptr_rdata[15] == 1, "R4 receive bit readback", ptr_rdata[15], 1);
  endtask

  task automatic t_flush;
    logic [31:0] d;
    load_ptr(C_RD_AI, 11'h000);
    host_read(2'd0, d);
    load_ptr(C_RD_AI, 11'h300);
    host_read(2'd2, d);
    check(d == exp_read(2, 'h300, 2), "R7 reload flushes prefetch", d, exp_read(2, 'h300, 2));
  endtask

  task automatic t_fixed;
    logic [31:0] d0, d1;
    load_ptr(C_RD_FX, 11'h013);
    check(ptr_rdata[10:0] == 11'h010, "R3 forced alignment", ptr_rdata[10:0], 11'h010);
    check(misalign_err == 1, "R3 misalign flagged", misalign_err, 1);
    host_read(2'd2, d0); host_read(2'd2, d1);
    check(d0 == exp_read(2, 'h010, 2) && d1 == d0, "R3 same dword twice", d1, exp_read(2, 'h010, 2));
    check(ptr_rdata[10:0] == 11'h010, "R3 no step on read", ptr_rdata[10:0], 11'h010);
    load_ptr(C_WR_FX, 11'h020);
    check(misalign_err == 0, "R3 aligned load clears flag", misalign_err, 0);
    host_write(2'd2, 32'h1111_1111); host_write(2'd2, 32'h2222_2222);
    repeat (4) @(negedge clk);
    check(mem[2][8] == 32'h2222_2222, "R3 writes hit same dword", mem[2][8], 32'h2222_2222);
    check(ptr_rdata[10:0] == 11'h020, "R3 no step on write", ptr_rdata[10:0], 11'h020);
  endtask

  task automatic t_write;
    logic [31:0] exp20;
    tx_pkt_num = 6'd3;
    exp20 = {16'hCDEF, 8'h5C, 8'hAB};
    load_ptr(C_WR_AI, 11'h080);
    host_write(2'd0, 32'h0000_00AB);
    check(ptr_rdata[11] == 1, "R8 pending flag set", ptr_rdata[11], 1);
    host_write(2'd0, 32'h0000_005C);
    host_write(2'd1, 32'h0000_CDEF);
    host_write(2'd2, 32'h1234_5678);
    repeat (4) @(negedge clk);
    check(ptr_rdata[11] == 0, "R8 pending flag clear", ptr_rdata[11], 0);
    check(mem[3][32] == exp20, "R8 byte lanes merged", mem[3][32], exp20);
    check(mem[3][33] == 32'h1234_5678, "R8 dword written", mem[3][33], 32'h1234_5678);
    check(ptr_rdata[10:0] == 11'h088, "R2 write steps", ptr_rdata[10:0], 11'h088);
  endtask

  task automatic t_wrong_dir;
    int r0, w0;
    load_ptr(C_WR_AI, 11'h100);
    r0 = rd_reqs;
    @(negedge clk); dat_rd = 1; dat_size = 2'd2;
    @(negedge clk); dat_rd = 0;
    repeat (2) @(negedge clk);
    check(ptr_rdata[10:0] == 11'h100 && rd_reqs == r0, "R9 read in write mode ignored", ptr_rdata[10:0], 11'h100);
    load_ptr(C_RD_AI, 11'h100);
    repeat (4) @(negedge clk);
    w0 = wr_reqs;
    @(negedge clk); dat_wr = 1; dat_wdata = 32'hDEAD_BEEF;
    @(negedge clk); dat_wr = 0;
    repeat (3) @(negedge clk);
    check(ptr_rdata[10:0] == 11'h100 && wr_reqs == w0, "R9 write in read mode ignored", 32'(wr_reqs - w0), 0);
  endtask

  task automatic t_early;
    load_ptr(4'b0101, 11'h000);
    check(early_tx_en == 1 && ptr_rdata[12] == 1, "R10 early transmit set", {early_tx_en, ptr_rdata[12]}, 2'b11);
    load_ptr(4'b0100, 11'h000);
    check(early_tx_en == 0 && ptr_rdata[12] == 0, "R10 early transmit clear", {early_tx_en, ptr_rdata[12]}, 0);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int p = 0; p < 4; p++)
      for (int w = 0; w < 512; w++) mem[p][w] = pat(p, w);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_load();
    t_prefetch_step();
    t_ahead();
    t_pkt_select();
    t_flush();
    t_fixed();
    t_write();
    t_wrong_dir();
    t_early();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule